// File: doc/BRIEF.md
# UART Baud Tick Generator with Selectable Prescaler

This block turns the reference clock of one serial channel into the timing enables that its transmitter and receiver consume. The reference first passes through a prescaler that either passes every cycle or passes one cycle in four. A 16-bit programmable divisor then counts the prescaled steps. It emits a one-cycle sampling tick at sixteen times the bit rate and a one-cycle bit tick on every sixteenth sampling tick. The bit rate is therefore reference / (prescale × 16 × divisor).

The divisor is loaded as two byte writes, in the way the classic divisor latches are loaded. The prescaler choice is taken from a board strap pin whenever reset is held. After reset, software can replace it through the top bit of a modem-control byte write. Any write restarts the counting chain, so a new rate applies from a clean phase. A divisor of zero parks the generator with both ticks low.

Top module: `uart_rate_gen`

## Requirements
- R1: While reset is held and after it is released, both tick outputs stay low. Reset clears the divisor to zero, so no tick appears until a non-zero divisor is written.
- R2: Each reset cycle samples `clk_sel_pin`. A high level selects the divide-by-4 prescale and a low level selects divide-by-1.
- R3: A `mcr_wr` write sets the prescale from bit 7 of `wr_data`: 1 selects divide-by-4 and 0 selects divide-by-1. The other seven bits have no effect on the tick timing.
- R4: While the divisor is zero, `tick16_o` and `tick1_o` stay low.
- R5: With prescale P and a non-zero divisor D, `tick16_o` is a single-cycle pulse that repeats every P×D clock cycles.
- R6: `tick1_o` pulses in the same cycle as every sixteenth `tick16_o` pulse, so its period is 16×P×D cycles. It never pulses without `tick16_o`.
- R7: Any write (`lo_wr`, `hi_wr` or `mcr_wr`) restarts the chain. No tick appears in the cycle after the write edge. The first `tick16_o` appears P×D cycles after the write edge and the first `tick1_o` appears 16×P×D cycles after it.
- R8: `lo_wr` loads `wr_data` into divisor bits 7:0 and `hi_wr` loads it into divisor bits 15:8. The other byte keeps its value.
- R9: With P = 1 and D = 1, `tick16_o` is high on every cycle and `tick1_o` fires every 16 cycles. At a 14.7456 MHz reference this gives 921.6 kbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel_pin | input | 1 | Strap giving the prescale chosen at reset (1 = divide by 4) |
| mcr_wr | input | 1 | Write strobe for the modem-control byte; bit 7 picks the prescale |
| lo_wr | input | 1 | Write strobe for the divisor low byte |
| hi_wr | input | 1 | Write strobe for the divisor high byte |
| wr_data | input | 8 | Write data shared by the three strobes |
| tick16_o | output | 1 | One-cycle sampling enable at 16× the bit rate |
| tick1_o | output | 1 | One-cycle bit enable |

## Verification
Every write restarts the chain at its own clock edge. From that edge the n-th sampling tick is due exactly n×P×D cycles later and the n-th bit tick exactly 16×n×P×D cycles later, because both outputs come from one register stage. The driver records the edge number of each write and queues the absolute cycle numbers at which each tick must appear. A monitor samples on the falling edge and compares each observed pulse against the head of its queue, so a pulse that comes one cycle early, one cycle late or lasts two cycles is reported. For zero divisors and the cycles after reset, the monitor runs in a strict window where any pulse at all counts as a failure.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;

    // Prescale mode: the encoding matches the control bit and the strap level.
    typedef enum logic {
        PRESC_FAST = 1'b0,
        PRESC_SLOW = 1'b1
    } presc_mode_e;

endpackage

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
    parameter int unsigned SLOW_RATIO = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  uart_rate_pkg::presc_mode_e mode,
    output logic                      step
);
    localparam int unsigned CNT_W = (SLOW_RATIO > 2) ? $clog2(SLOW_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_RATIO - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       slow;

    always_comb begin
        slow     = (mode == uart_rate_pkg::PRESC_SLOW);
        st_d     = st_q;
        step     = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (slow) begin
            step     = (st_q.cnt == LAST);
            st_d.cnt = step ? '0 : st_q.cnt + CNT_W'(1);
        end else begin
            step     = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] divisor,
    output logic             fire,
    output logic             tick16
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       active;

    always_comb begin
        active    = (divisor != '0);
        st_d      = st_q;
        fire      = 1'b0;
        if (restart || !active) begin
            st_d.cnt = '0;
        end else if (step) begin
            fire     = (st_q.cnt == divisor - DIV_W'(1));
            st_d.cnt = fire ? '0 : st_q.cnt + DIV_W'(1);
        end
        st_d.tick = fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick16 = st_q.tick;
endmodule

// File: rtl/rate_bitdiv.sv
module rate_bitdiv #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fire,
    output logic tick1
);
    localparam int unsigned BCNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [BCNT_W-1:0] LAST = BCNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [BCNT_W-1:0] cnt;
        logic              tick;
    } bit_state_t;

    bit_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (fire) begin
            st_d.tick = (st_q.cnt == LAST);
            st_d.cnt  = st_d.tick ? '0 : st_q.cnt + BCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick1 = st_q.tick;
endmodule

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned SLOW_RATIO = 4,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_sel_pin,
    input  logic              mcr_wr,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick16_o,
    output logic              tick1_o
);
    import uart_rate_pkg::*;

    localparam int unsigned DIV_W   = 2 * BYTE_W;
    localparam int unsigned SEL_BIT = BYTE_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0] divisor;
        presc_mode_e      mode;
    } cfg_state_t;

    cfg_state_t       st_d, st_q;
    logic             restart;
    logic             step;
    logic             fire;
    logic [DIV_W-1:0] div_q;
    logic             slow_q;

    always_comb begin
        st_d    = st_q;
        restart = mcr_wr | lo_wr | hi_wr;
        if (lo_wr) begin
            st_d.divisor[BYTE_W-1:0] = wr_data;
        end
        if (hi_wr) begin
            st_d.divisor[DIV_W-1:BYTE_W] = wr_data;
        end
        if (mcr_wr) begin
            st_d.mode = presc_mode_e'(wr_data[SEL_BIT]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.divisor <= '0;
            st_q.mode    <= presc_mode_e'(clk_sel_pin);
        end else begin
            st_q <= st_d;
        end
    end

    assign div_q  = st_q.divisor;
    assign slow_q = (st_q.mode == PRESC_SLOW);

    rate_prescaler #(.SLOW_RATIO(SLOW_RATIO)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .mode    (st_q.mode),
        .step    (step)
    );

    rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (step),
        .divisor (st_q.divisor),
        .fire    (fire),
        .tick16  (tick16_o)
    );

    rate_bitdiv #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .fire    (fire),
        .tick1   (tick1_o)
    );
endmodule

// File: rtl/uart_rate_gen_chk.sv
module uart_rate_gen_chk #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mcr_wr,
    input logic              lo_wr,
    input logic              hi_wr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              tick16_o,
    input logic              tick1_o,
    input logic [DIV_W-1:0]  div_q,
    input logic              slow_q
);
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !tick16_o && !tick1_o);

    a_r3_mcr_picks_prescale: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_wr |=> slow_q == $past(wr_data[BYTE_W-1]));

    a_r8_low_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr && !hi_wr |=> div_q[BYTE_W-1:0] == $past(wr_data)
                         && div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W]));

    a_r8_high_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && !lo_wr |=> div_q[DIV_W-1:BYTE_W] == $past(wr_data)
                         && div_q[BYTE_W-1:0] == $past(div_q[BYTE_W-1:0]));

    a_r4_zero_divisor_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        div_q == '0 |=> !tick16_o && !tick1_o);

    a_r5_single_cycle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o && (slow_q || div_q > DIV_W'(1)) |=> !tick16_o);

    a_r6_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        tick1_o |-> tick16_o);

    a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr || lo_wr || hi_wr) |=> !tick16_o && !tick1_o);
endmodule

bind uart_rate_gen uart_rate_gen_chk #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mcr_wr   (mcr_wr),
    .lo_wr    (lo_wr),
    .hi_wr    (hi_wr),
    .wr_data  (wr_data),
    .tick16_o (tick16_o),
    .tick1_o  (tick1_o),
    .div_q    (div_q),
    .slow_q   (slow_q)
);

// File: tb/uart_rate_gen_test.sv
`timescale 1ns/1ps
module uart_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel_pin = 1'b0;
    logic       mcr_wr = 1'b0;
    logic       lo_wr = 1'b0;
    logic       hi_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick16_o;
    logic       tick1_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int spur     = 0;
    bit strict   = 1'b0;

    int    exp16[$];
    int    exp1[$];
    string tag16[$];
    string tag1[$];

    always #4 clk = ~clk;

    uart_rate_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_sel_pin (clk_sel_pin),
        .mcr_wr      (mcr_wr),
        .lo_wr       (lo_wr),
        .hi_wr       (hi_wr),
        .wr_data     (wr_data),
        .tick16_o    (tick16_o),
        .tick1_o     (tick1_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    // Monitor: compare each observed pulse with the head of its queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tick16_o) begin
                if (exp16.size() > 0) begin
                    check(cyc == exp16[0], tag16[0], cyc, exp16[0]);
                    void'(exp16.pop_front());
                    void'(tag16.pop_front());
                end else if (strict) begin
                    spur++;
                end
            end
            if (tick1_o) begin
                if (exp1.size() > 0) begin
                    check(cyc == exp1[0], tag1[0], cyc, exp1[0]);
                    void'(exp1.pop_front());
                    void'(tag1.pop_front());
                end else if (strict) begin
                    spur++;
                end
            end
        end
    end

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n       = 1'b0;
        clk_sel_pin = strap;
        repeat (3) @(negedge clk);
        check(tick16_o == 1'b0 && tick1_o == 1'b0, "R1", tick16_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        clk_sel_pin = ~strap;
    endtask

    // kind: 0 = control byte, 1 = divisor low, 2 = divisor high
    task automatic wr(input int kind, input logic [7:0] data, output int w);
        @(negedge clk);
        wr_data = data;
        mcr_wr  = (kind == 0);
        lo_wr   = (kind == 1);
        hi_wr   = (kind == 2);
        @(negedge clk);
        mcr_wr = 1'b0;
        lo_wr  = 1'b0;
        hi_wr  = 1'b0;
        w      = cyc;
    endtask

    task automatic set_div(input logic [15:0] d, output int w);
        int tmp;
        wr(2, d[15:8], tmp);
        wr(1, d[7:0], w);
    endtask

    task automatic expect_run(input int per, input int n16, input int n1,
                              input string tag, input int w);
        int limit;
        int waited;
        for (int k = 1; k <= n16; k++) begin
            exp16.push_back(w + k * per);
            tag16.push_back(tag);
        end
        for (int k = 1; k <= n1; k++) begin
            exp1.push_back(w + k * 16 * per);
            tag1.push_back(tag);
        end
        limit  = per * 16 * n1 + per * n16 + 20;
        waited = 0;
        while ((exp16.size() > 0 || exp1.size() > 0) && waited < limit) begin
            @(negedge clk);
            waited++;
        end
        if (exp16.size() > 0 || exp1.size() > 0) begin
            check(1'b0, tag, exp16.size() + exp1.size(), 0);
            exp16.delete();
            exp1.delete();
            tag16.delete();
            tag1.delete();
        end
    endtask

    task automatic quiet_window(input int len, input string tag);
        spur   = 0;
        strict = 1'b1;
        repeat (len) @(negedge clk);
        strict = 1'b0;
        check(spur == 0, tag, spur, 0);
    endtask

    initial begin
        int w;
        // R1: reset state, strap low
        do_reset(1'b0);
        quiet_window(40, "R1");

        // R9: fastest rate, prescale 1 from strap
        set_div(16'd1, w);
        expect_run(1, 20, 3, "R9", w);
        // R5 / R6: prescale 1, divisors 2 and 12
        set_div(16'd2, w);
        expect_run(2, 10, 2, "R5", w);
        set_div(16'd12, w);
        expect_run(12, 5, 2, "R6", w);

        // R3: control bit 7 high picks divide-by-4; restart at the write (R7)
        wr(0, 8'h80, w);
        expect_run(48, 5, 1, "R3", w);
        set_div(16'd1, w);
        expect_run(4, 8, 2, "R5", w);
        set_div(16'd2, w);
        expect_run(8, 6, 1, "R5", w);

        // R3: bit 7 low, all other bits set, gives divide-by-1
        wr(0, 8'h7F, w);
        expect_run(2, 6, 1, "R3", w);

        // R7: restart in the middle of a run
        set_div(16'd12, w);
        repeat (7) @(negedge clk);
        wr(1, 8'd12, w);
        expect_run(12, 3, 1, "R7", w);

        // R8: byte placement, high byte 1 and low byte 0 gives 256
        set_div(16'h0100, w);
        expect_run(256, 3, 1, "R8", w);

        // R5: largest divisor, prescale 1
        set_div(16'hFFFF, w);
        expect_run(65535, 1, 0, "R5", w);

        // R4: zero divisor stops both ticks
        set_div(16'h0000, w);
        quiet_window(300, "R4");

        // R2: strap high at reset gives divide-by-4
        do_reset(1'b1);
        quiet_window(20, "R1");
        set_div(16'd2, w);
        expect_run(8, 4, 1, "R2", w);

        // R2 then R3: strap high, control write clears to divide-by-1
        do_reset(1'b1);
        set_div(16'd3, w);
        expect_run(12, 2, 0, "R2", w);
        wr(0, 8'h00, w);
        expect_run(3, 6, 1, "R3", w);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule